// File: doc/BRIEF.md
# Endpoint Buffer Readiness Interrupt Aggregator

This block gathers buffer events from six endpoints of a USB device controller and folds them into one active-low interrupt request. Two kinds of event arrive as one-cycle pulses in the system clock domain. A "ready" pulse means that an endpoint's buffer can now be read or written. A "nak" pulse arrives when an IN or OUT token has just finished and the endpoint answered NAK because its buffer was not ready.

Each event sets a sticky per-endpoint status bit. Two read-only summary flags are the OR of all ready bits and the OR of all not-ready bits. Each summary flag has its own enable. The interrupt line goes low while any enabled summary flag is 1. A summary flag cannot be cleared directly. Software clears it by writing 0 to the status bits beneath it through a small register port.

The register port has a write strobe, a 2-bit address and write data. Read data is combinational from the address.

Top module: `ebi_buf_irq`

## Requirements
- R1: After reset, both status registers and both enables read as 0, and `irq_n` is 1.
- R2: A pulse on `ev_rdy[i]` sets ready status bit i. The bit is visible at address 0, bit i, from the clock edge that samples the pulse.
- R3: A pulse on `ev_nak[i]` sets not-ready status bit i. The bit is visible at address 1, bit i, from the clock edge that samples the pulse.
- R4: A write to address 0 or address 1 clears each status bit whose data bit is 0 and leaves unchanged each bit whose data bit is 1.
- R5: When a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: Address 2 reads as follows:
  - bit 0: ready enable
  - bit 1: not-ready enable
  - bit 2: ready summary (OR of the ready bits)
  - bit 3: not-ready summary (OR of the not-ready bits)
  - upper bits: 0

  Writes to bits 2 and 3 have no effect.
- R7: The enables are written through bits 0 and 1 of address 2 and keep their value until written again.
- R8: `irq_n` is 0 exactly when (ready enable AND ready summary) OR (not-ready enable AND not-ready summary).
- R9: Status bits are sticky. They do not change in a cycle with no event and no clearing write to their own address. Address 3 reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rdy | input | NUM_EP | Per-endpoint buffer-ready pulses |
| ev_nak | input | NUM_EP | Per-endpoint token-end NAK pulses (buffer not ready) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW (max(NUM_EP,4)) | Register write data |
| reg_rdata | output | DW (max(NUM_EP,4)) | Register read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The main function is driven with the following patterns:
- single-endpoint pulses on the lowest and highest endpoints;
- multi-endpoint bursts;
- write-zero and write-one masks;
- events that coincide with clearing writes.

Together these separate a correct per-bit mask from a whole-register clear, and a set-wins merge from a clear-wins merge. Enable sweeps leave one summary set while its enable is off and the other summary's enable on. This shows whether each enable gates only its own flag. Writes that aim at the summary bits and at the unused address show that these writes cannot disturb the state.

// File: rtl/ebi_pkg.sv
`timescale 1ns/1ps
package ebi_pkg;
  localparam logic [1:0] ADR_RDY  = 2'd0;
  localparam logic [1:0] ADR_NRDY = 2'd1;
  localparam logic [1:0] ADR_CTRL = 2'd2;

  localparam int unsigned CB_EN_RDY   = 0;
  localparam int unsigned CB_EN_NRDY  = 1;
  localparam int unsigned CB_SUM_RDY  = 2;
  localparam int unsigned CB_SUM_NRDY = 3;

  // Next value of one sticky bit: a set event overrides a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Interrupt request (active high) from the enables and the summaries.
  function automatic logic irq_req(input logic [1:0] en, input logic [1:0] sum);
    return |(en & sum);
  endfunction
endpackage

// File: rtl/ebi_status_bank.sv
`timescale 1ns/1ps
module ebi_status_bank #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o,
  output logic         any_o
);
  import ebi_pkg::*;

  logic [W-1:0] stat_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else        stat_q[g] <= sticky_next(stat_q[g], set_i[g], clr_i[g]);
    end
  end

  assign stat_o = stat_q;
  assign any_o  = |stat_q;
endmodule

// File: rtl/ebi_reg_if.sv
`timescale 1ns/1ps
module ebi_reg_if #(
  parameter int unsigned NUM_EP = 6,
  parameter int unsigned DW     = 6
) (
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [NUM_EP-1:0] rdy_stat,
  input  logic [NUM_EP-1:0] nrdy_stat,
  input  logic [1:0]        en,
  input  logic [1:0]        sum,
  output logic [NUM_EP-1:0] clr_rdy,
  output logic [NUM_EP-1:0] clr_nrdy,
  output logic              en_we,
  output logic [1:0]        en_wdata,
  output logic [DW-1:0]     reg_rdata
);
  import ebi_pkg::*;

  logic wr_rdy, wr_nrdy;

  assign wr_rdy   = reg_we && (reg_addr == ADR_RDY);
  assign wr_nrdy  = reg_we && (reg_addr == ADR_NRDY);
  assign en_we    = reg_we && (reg_addr == ADR_CTRL);
  assign clr_rdy  = wr_rdy  ? ~reg_wdata[NUM_EP-1:0] : '0;
  assign clr_nrdy = wr_nrdy ? ~reg_wdata[NUM_EP-1:0] : '0;
  assign en_wdata = {reg_wdata[CB_EN_NRDY], reg_wdata[CB_EN_RDY]};

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_RDY:  reg_rdata[NUM_EP-1:0] = rdy_stat;
      ADR_NRDY: reg_rdata[NUM_EP-1:0] = nrdy_stat;
      ADR_CTRL: begin
        reg_rdata[CB_EN_RDY]   = en[0];
        reg_rdata[CB_EN_NRDY]  = en[1];
        reg_rdata[CB_SUM_RDY]  = sum[0];
        reg_rdata[CB_SUM_NRDY] = sum[1];
      end
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ebi_irq_gen.sv
`timescale 1ns/1ps
module ebi_irq_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_we,
  input  logic [1:0] en_wdata,
  input  logic [1:0] sum,
  output logic [1:0] en_o,
  output logic       irq_n
);
  import ebi_pkg::*;

  logic [1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_wdata;
  end

  assign en_o  = en_q;
  assign irq_n = ~irq_req(en_q, sum);
endmodule

// File: rtl/ebi_buf_irq.sv
`timescale 1ns/1ps
module ebi_buf_irq #(
  parameter  int unsigned NUM_EP = 6,
  localparam int unsigned DW     = (NUM_EP > 4) ? NUM_EP : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_rdy,
  input  logic [NUM_EP-1:0] ev_nak,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_n
);
  logic [NUM_EP-1:0] rdy_stat, nrdy_stat, clr_rdy, clr_nrdy;
  logic              sum_rdy, sum_nrdy, en_we;
  logic [1:0]        en, en_wdata;

  ebi_status_bank #(.W(NUM_EP)) u_rdy_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_rdy), .clr_i(clr_rdy),
    .stat_o(rdy_stat), .any_o(sum_rdy)
  );

  ebi_status_bank #(.W(NUM_EP)) u_nrdy_bank (
    .clk(clk), .rst_n(rst_n), .set_i(ev_nak), .clr_i(clr_nrdy),
    .stat_o(nrdy_stat), .any_o(sum_nrdy)
  );

  ebi_reg_if #(.NUM_EP(NUM_EP), .DW(DW)) u_reg_if (
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rdy_stat(rdy_stat), .nrdy_stat(nrdy_stat), .en(en),
    .sum({sum_nrdy, sum_rdy}),
    .clr_rdy(clr_rdy), .clr_nrdy(clr_nrdy),
    .en_we(en_we), .en_wdata(en_wdata), .reg_rdata(reg_rdata)
  );

  ebi_irq_gen u_irq_gen (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
    .sum({sum_nrdy, sum_rdy}), .en_o(en), .irq_n(irq_n)
  );
endmodule

// File: rtl/ebi_buf_irq_chk.sv
`timescale 1ns/1ps
module ebi_buf_irq_chk #(
  parameter int unsigned NUM_EP = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ev_rdy,
  input logic [NUM_EP-1:0] ev_nak,
  input logic [NUM_EP-1:0] clr_rdy,
  input logic [NUM_EP-1:0] clr_nrdy,
  input logic [NUM_EP-1:0] rdy_stat,
  input logic [NUM_EP-1:0] nrdy_stat,
  input logic              sum_rdy,
  input logic              sum_nrdy,
  input logic [1:0]        en,
  input logic              irq_n
);
  // R2 / R5: every ready event leaves its bit set on the next cycle
  a_r2_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_rdy) |=> ((rdy_stat & $past(ev_rdy)) == $past(ev_rdy)));

  // R3 / R5: every nak event leaves its bit set on the next cycle
  a_r3_nak_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_nak) |=> ((nrdy_stat & $past(ev_nak)) == $past(ev_nak)));

  // R4 / R9: a bit falls only where a clearing write targeted it
  a_r4_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rdy_stat) & ~rdy_stat & ~$past(clr_rdy)) == '0) &&
    (($past(nrdy_stat) & ~nrdy_stat & ~$past(clr_nrdy)) == '0));

  // R9: a bit rises only where an event arrived
  a_r9_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdy_stat & ~$past(rdy_stat) & ~$past(ev_rdy)) == '0) &&
    ((nrdy_stat & ~$past(nrdy_stat) & ~$past(ev_nak)) == '0));

  // R6: the summaries track their status banks
  a_r6_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_rdy == (rdy_stat != '0)) && (sum_nrdy == (nrdy_stat != '0)));

  // R8: interrupt low only with an enabled, set summary
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> ((en[0] && (rdy_stat != '0)) || (en[1] && (nrdy_stat != '0))));
endmodule

bind ebi_buf_irq ebi_buf_irq_chk #(.NUM_EP(NUM_EP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_rdy(ev_rdy), .ev_nak(ev_nak),
  .clr_rdy(clr_rdy), .clr_nrdy(clr_nrdy), .rdy_stat(rdy_stat),
  .nrdy_stat(nrdy_stat), .sum_rdy(sum_rdy), .sum_nrdy(sum_nrdy),
  .en(en), .irq_n(irq_n)
);

// File: tb/ebi_buf_irq_tb.sv
`timescale 1ns/1ps
module ebi_buf_irq_tb;
  localparam int NEP = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NEP-1:0] ev_rdy = '0, ev_nak = '0;
  logic           reg_we = 1'b0;
  logic [1:0]     reg_addr = 2'd0;
  logic [NEP-1:0] reg_wdata = '0;
  logic [NEP-1:0] reg_rdata;
  logic           irq_n;
  int             n_tests = 0, n_fail = 0;
  bit             done = 1'b0;

  always #2.5 clk = ~clk;

  ebi_buf_irq #(.NUM_EP(NEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_rdy(ev_rdy), .ev_nak(ev_nak),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  typedef struct packed {
    logic [5:0] rdy;
    logic [5:0] nak;
    logic       we;
    logic [1:0] adr;
    logic [5:0] wd;
    logic [5:0] exp_r;
    logic [5:0] exp_n;
    logic       exp_irq_n;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{6'h01, 6'h00, 1'b0, 2'd0, 6'h00, 6'h01, 6'h00, 1'b1}, // R2 ep0, enables off
    '{6'h00, 6'h00, 1'b1, 2'd2, 6'h03, 6'h01, 6'h00, 1'b0}, // R7 enable both
    '{6'h00, 6'h20, 1'b0, 2'd0, 6'h00, 6'h01, 6'h20, 1'b0}, // R3 ep5
    '{6'h00, 6'h00, 1'b1, 2'd0, 6'h3E, 6'h00, 6'h20, 1'b0}, // R4 clear ep0
    '{6'h00, 6'h00, 1'b1, 2'd1, 6'h3F, 6'h00, 6'h20, 1'b0}, // R4 all-ones keeps
    '{6'h00, 6'h00, 1'b1, 2'd1, 6'h1F, 6'h00, 6'h00, 1'b1}, // R4 clear ep5
    '{6'h2A, 6'h00, 1'b0, 2'd0, 6'h00, 6'h2A, 6'h00, 1'b0}, // R2 burst
    '{6'h04, 6'h00, 1'b1, 2'd0, 6'h00, 6'h04, 6'h00, 1'b0}, // R5 set beats clear
    '{6'h00, 6'h15, 1'b1, 2'd1, 6'h00, 6'h04, 6'h15, 1'b0}, // R5 set beats clear
    '{6'h00, 6'h00, 1'b1, 2'd2, 6'h02, 6'h04, 6'h15, 1'b0}, // R8 nak enable only
    '{6'h00, 6'h00, 1'b1, 2'd1, 6'h00, 6'h04, 6'h00, 1'b1}, // R8 ready masked
    '{6'h00, 6'h00, 1'b1, 2'd2, 6'h01, 6'h04, 6'h00, 1'b0}, // R8 ready enable only
    '{6'h00, 6'h00, 1'b1, 2'd0, 6'h3B, 6'h00, 6'h00, 1'b1}, // R4 clear ep2
    '{6'h00, 6'h00, 1'b1, 2'd2, 6'h0C, 6'h00, 6'h00, 1'b1}  // R6 summary write ignored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = {2'b00, reg_rdata};
  endtask

  task automatic cyc(input logic [5:0] r, input logic [5:0] n, input logic we,
                     input logic [1:0] a, input logic [5:0] wd);
    @(negedge clk);
    ev_rdy = r; ev_nak = n; reg_we = we; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    #1;
    ev_rdy = '0; ev_nak = '0; reg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, sampled while reset is held
    rd(2'd0, v); check("R1 ready status", v, 8'h00);
    rd(2'd1, v); check("R1 nrdy status", v, 8'h00);
    rd(2'd2, v); check("R1 control", v, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].rdy, VEC[i].nak, VEC[i].we, VEC[i].adr, VEC[i].wd);
      rd(2'd0, v); check($sformatf("R2/R4/R5 vec %0d ready", i), v, {2'b00, VEC[i].exp_r});
      rd(2'd1, v); check($sformatf("R3/R4/R5 vec %0d nrdy", i), v, {2'b00, VEC[i].exp_n});
      check($sformatf("R8 vec %0d irq_n", i), {7'd0, irq_n}, {7'd0, VEC[i].exp_irq_n});
    end
    rd(2'd2, v); check("R6 summary bits not writable", v, 8'h00);

    // R6: summaries visible with enables off; R7: enables kept
    cyc(6'h20, 6'h01, 1'b0, 2'd0, 6'h00);
    rd(2'd2, v); check("R6 both summaries", v, 8'h0C);
    check("R8 disabled irq_n high", {7'd0, irq_n}, 8'h01);
    cyc(6'h00, 6'h00, 1'b1, 2'd2, 6'h03);
    cyc(6'h00, 6'h00, 1'b0, 2'd0, 6'h00);
    rd(2'd2, v); check("R7 enables held", v, 8'h0F);

    // R9: idle cycles and unused address leave state alone
    repeat (4) cyc(6'h00, 6'h00, 1'b0, 2'd0, 6'h00);
    cyc(6'h00, 6'h00, 1'b1, 2'd3, 6'h00);
    rd(2'd0, v); check("R9 ready sticky", v, 8'h20);
    rd(2'd1, v); check("R9 nrdy sticky", v, 8'h01);
    rd(2'd3, v); check("R9 address 3 reads zero", v, 8'h00);
    rd(2'd2, v); check("R9 control unchanged", v, 8'h0F);

    // R4: clearing ready leaves nrdy summary driving irq
    cyc(6'h00, 6'h00, 1'b1, 2'd0, 6'h00);
    rd(2'd2, v); check("R4 ready summary cleared", v, 8'h0B);
    check("R8 irq held by nrdy", {7'd0, irq_n}, 8'h00);
    cyc(6'h00, 6'h00, 1'b1, 2'd1, 6'h00);
    check("R8 irq released", {7'd0, irq_n}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule